// File: doc/BRIEF.md
# Two-Plane NAND Block Erase Sequencer

This block sits on the host side of a raw NAND flash bus. It erases one block in each of two planes as a single operation. A request carries two row addresses. The sequencer first queues the block in one plane with a setup command, three row-address cycles and a queue-confirm command. It waits out the short busy interval that follows. It then sends the second plane's block with the same setup command, its three row-address cycles and the start command, and waits through the long erase busy.

When the device reports ready, the sequencer reads the status byte. If the error bit is clear, the operation has passed. If it is set, the sequencer sends a per-plane status command once for each plane's row address and records which plane reported the error. Only erase is ever issued, so both planes always run the same operation type.

A request whose two addresses select the same plane is refused at once, with no bus activity. A programmable cycle limit guards every wait on the ready/busy pin, so a device that never becomes ready ends the operation with a timeout error instead of a hang.

Top module: `nand_dual_erase`

## Requirements
- R1: `req_ready` is high only when idle, and a request is taken when `req_valid` and `req_ready` are both high at a clock edge. `busy` is high from the cycle after acceptance up to and including the single cycle in which `done` is high. After that cycle both `busy` and `done` are low.
- R2: The first half is the command byte 60h, then three address bytes of row A, then the command byte D1h. Address bytes go low byte first (row bits 7:0, 15:8, 23:16). A command byte is latched with CLE=1 and ALE=0, and an address byte with ALE=1 and CLE=0. Each byte is latched on the rising edge of `nand_we_n`, and `nand_ce_n` is low whenever `nand_we_n` or `nand_re_n` is low.
- R3: After D1h and after D0h, no further write or read cycle starts until `nand_rb` is high again. Before the sequencer samples `nand_rb`, it waits `WB_CYC` cycles.
- R4: The second half is 60h, then the three address bytes of row B, then D0h.
- R5: In both driven row addresses, the page bits [PAGE_BITS-1:0] are zero and bit PAGE_BITS is that request's own plane bit. The block bits above PAGE_BITS come from `req_row_b` in both addresses.
- R6: A request with `req_row_a[PAGE_BITS] == req_row_b[PAGE_BITS]` ends with `done`, `addr_err`=1 and `fail`=1, and no byte is ever written. `nand_ce_n` stays high throughout.
- R7: After the final ready, the sequencer writes 70h and reads one status byte. If status bit 0 is 0, the result is `fail`=0 and `plane_fail`=0, and no further byte is written.
- R8: If status bit 0 is 1, the sequencer writes 78h, the three bytes of row A, and reads a byte. It then writes 78h, the three bytes of row B, and reads a byte. `plane_fail[p]` takes bit 0 of the byte read for the address whose plane bit is p, and `fail`=1.
- R9: If `nand_rb` is not high within `tmo_limit` cycles of the start of a wait, the operation ends with `done`, `fail`=1 and `timeout_err`=1. The chip enable is released, and no further byte is written for that request.
- R10: CLE and ALE are never high together, and write-enable and read-enable are never low together. `nand_io_oe` is high during every write strobe and low during every read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Erase request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_row_a | input | 24 | Row address of the first plane's block |
| req_row_b | input | 24 | Row address of the second plane's block |
| tmo_limit | input | TMO_W | Maximum cycles per ready wait |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Operation did not succeed |
| plane_fail | output | 2 | Erase error per plane number |
| timeout_err | output | 1 | A ready wait exceeded the limit |
| addr_err | output | 1 | Both addresses selected the same plane |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, data latched on rising edge |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | Byte driven to the flash |
| nand_io_oe | output | 1 | Output enable for `nand_io_out` |
| nand_io_in | input | 8 | Byte returned by the flash |
| nand_rb | input | 1 | Ready (1) / busy (0) from the flash |

## Verification
The hardest paths to reach are the per-plane status reads and the timeout abort. They run only when the flash model returns a set error bit after the erase, or when it holds ready/busy low past the limit. The bench's flash model has a programmable status byte, per-plane error bits chosen by the plane bit in the first address byte after 78h, and separate busy lengths for the queue phase and the erase phase. Directed cases time out in each of the two waits and fail one plane, the other plane or both. Seeded random cases vary the rows, busy lengths and error bits, and sometimes repeat the plane bit.

// File: rtl/nde_pkg.sv
package nde_pkg;

    localparam int ROW_BYTES = 3;
    localparam int ROW_W     = 8 * ROW_BYTES;

    localparam logic [7:0] CMD_SETUP  = 8'h60;
    localparam logic [7:0] CMD_QUEUE  = 8'hD1;
    localparam logic [7:0] CMD_START  = 8'hD0;
    localparam logic [7:0] CMD_STAT   = 8'h70;
    localparam logic [7:0] CMD_PSTAT  = 8'h78;

    localparam logic [4:0] STEP_RD_SR = 5'd13;
    localparam logic [4:0] STEP_RD_PA = 5'd18;
    localparam logic [4:0] STEP_RD_PB = 5'd23;

    typedef enum logic [1:0] {OP_CMD, OP_ADR, OP_RD, OP_WAIT} op_kind_e;

    typedef struct packed {
        op_kind_e   kind;
        logic [7:0] data;
    } bus_op_t;

    // Keep own plane bit, clear page bits, take block bits from src.
    function automatic logic [ROW_W-1:0] merge_row(input logic [ROW_W-1:0] own,
                                                   input logic [ROW_W-1:0] src,
                                                   input int pbits);
        logic [ROW_W-1:0] r;
        for (int i = 0; i < ROW_W; i++) begin
            if (i < pbits)       r[i] = 1'b0;
            else if (i == pbits) r[i] = own[i];
            else                 r[i] = src[i];
        end
        return r;
    endfunction

    function automatic bus_op_t mk(input op_kind_e k, input logic [7:0] d);
        bus_op_t o;
        o.kind = k;
        o.data = d;
        return o;
    endfunction

    // Program of the whole operation, one bus item per step.
    function automatic bus_op_t step_op(input logic [4:0] step,
                                        input logic [ROW_W-1:0] ra,
                                        input logic [ROW_W-1:0] rb);
        case (step)
            5'd0:  return mk(OP_CMD, CMD_SETUP);
            5'd1:  return mk(OP_ADR, ra[7:0]);
            5'd2:  return mk(OP_ADR, ra[15:8]);
            5'd3:  return mk(OP_ADR, ra[23:16]);
            5'd4:  return mk(OP_CMD, CMD_QUEUE);
            5'd5:  return mk(OP_WAIT, 8'h00);
            5'd6:  return mk(OP_CMD, CMD_SETUP);
            5'd7:  return mk(OP_ADR, rb[7:0]);
            5'd8:  return mk(OP_ADR, rb[15:8]);
            5'd9:  return mk(OP_ADR, rb[23:16]);
            5'd10: return mk(OP_CMD, CMD_START);
            5'd11: return mk(OP_WAIT, 8'h00);
            5'd12: return mk(OP_CMD, CMD_STAT);
            5'd13: return mk(OP_RD, 8'h00);
            5'd14: return mk(OP_CMD, CMD_PSTAT);
            5'd15: return mk(OP_ADR, ra[7:0]);
            5'd16: return mk(OP_ADR, ra[15:8]);
            5'd17: return mk(OP_ADR, ra[23:16]);
            5'd18: return mk(OP_RD, 8'h00);
            5'd19: return mk(OP_CMD, CMD_PSTAT);
            5'd20: return mk(OP_ADR, rb[7:0]);
            5'd21: return mk(OP_ADR, rb[15:8]);
            5'd22: return mk(OP_ADR, rb[23:16]);
            default: return mk(OP_RD, 8'h00);
        endcase
    endfunction

endpackage

// File: rtl/nde_bus_engine.sv
module nde_bus_engine
    import nde_pkg::*;
#(
    parameter int WB_CYC = 4,
    parameter int RD_CYC = 2,
    parameter int TMO_W  = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             op_valid,
    input  bus_op_t          op,
    input  logic [TMO_W-1:0] tmo_limit,
    input  logic             rb_ready,
    input  logic [7:0]       io_in,
    output logic             op_done,
    output logic             tmo_hit,
    output logic [7:0]       rd_data,
    output logic             cle,
    output logic             ale,
    output logic             we_n,
    output logic             re_n,
    output logic [7:0]       io_out,
    output logic             io_oe
);

    typedef enum logic [2:0] {E_IDLE, E_WLO, E_WHI, E_RD, E_WB, E_POLL} eng_st_e;

    localparam logic [TMO_W-1:0] WB_LAST = TMO_W'(WB_CYC - 1);
    localparam logic [TMO_W-1:0] RD_LAST = TMO_W'(RD_CYC - 1);

    eng_st_e          st;
    logic [TMO_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= E_IDLE;
            cnt     <= '0;
            op_done <= 1'b0;
            tmo_hit <= 1'b0;
            rd_data <= '0;
            cle     <= 1'b0;
            ale     <= 1'b0;
            we_n    <= 1'b1;
            re_n    <= 1'b1;
            io_out  <= '0;
            io_oe   <= 1'b0;
        end else begin
            op_done <= 1'b0;
            tmo_hit <= 1'b0;
            case (st)
                E_IDLE: begin
                    cle   <= 1'b0;
                    ale   <= 1'b0;
                    io_oe <= 1'b0;
                    cnt   <= '0;
                    if (op_valid && !op_done) begin
                        case (op.kind)
                            OP_CMD, OP_ADR: begin
                                cle    <= (op.kind == OP_CMD);
                                ale    <= (op.kind == OP_ADR);
                                io_out <= op.data;
                                io_oe  <= 1'b1;
                                we_n   <= 1'b0;
                                st     <= E_WLO;
                            end
                            OP_RD: begin
                                re_n <= 1'b0;
                                st   <= E_RD;
                            end
                            default: st <= E_WB;
                        endcase
                    end
                end
                E_WLO: begin
                    we_n <= 1'b1;
                    st   <= E_WHI;
                end
                E_WHI: begin
                    cle     <= 1'b0;
                    ale     <= 1'b0;
                    io_oe   <= 1'b0;
                    op_done <= 1'b1;
                    st      <= E_IDLE;
                end
                E_RD: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == RD_LAST) begin
                        rd_data <= io_in;
                        re_n    <= 1'b1;
                        op_done <= 1'b1;
                        st      <= E_IDLE;
                    end
                end
                E_WB: begin
                    cnt <= cnt + 1'b1;
                    if (cnt >= tmo_limit) begin
                        op_done <= 1'b1;
                        tmo_hit <= 1'b1;
                        st      <= E_IDLE;
                    end else if (cnt == WB_LAST) begin
                        st <= E_POLL;
                    end
                end
                default: begin
                    cnt <= cnt + 1'b1;
                    if (rb_ready) begin
                        op_done <= 1'b1;
                        st      <= E_IDLE;
                    end else if (cnt >= tmo_limit) begin
                        op_done <= 1'b1;
                        tmo_hit <= 1'b1;
                        st      <= E_IDLE;
                    end
                end
            endcase
        end
    end

    assert_cle_ale_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(cle && ale));
    assert_we_re_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(!we_n && !re_n));
    assert_oe_on_write_R10: assert property (@(posedge clk) disable iff (rst)
        (!we_n |-> io_oe) and (!re_n |-> !io_oe));
    assert_latch_has_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(we_n) |-> (cle || ale));
    assert_no_start_while_busy_R3: assert property (@(posedge clk) disable iff (rst)
        (st == E_POLL && !rb_ready) |=> (we_n && re_n));

endmodule

// File: rtl/nde_seq.sv
module nde_seq
    import nde_pkg::*;
#(
    parameter int PAGE_BITS = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [ROW_W-1:0] row_a,
    input  logic [ROW_W-1:0] row_b,
    output logic             busy,
    output logic             done,
    output logic             fail,
    output logic [1:0]       plane_fail,
    output logic             timeout_err,
    output logic             addr_err,
    output logic             ce_n,
    output logic             op_valid,
    output bus_op_t          op,
    input  logic             op_done,
    input  logic             tmo_hit,
    input  logic [7:0]       rd_data
);

    typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} seq_st_e;

    seq_st_e          st;
    logic [4:0]       step;
    logic [ROW_W-1:0] ra_q;
    logic [ROW_W-1:0] rb_q;
    logic             pa_q;
    logic             pb_q;
    logic             st_err;

    assign req_ready = (st == S_IDLE);
    assign busy      = (st != S_IDLE);
    assign done      = (st == S_FIN);
    assign op_valid  = (st == S_RUN);
    assign op        = step_op(step, ra_q, rb_q);
    assign st_err    = rd_data[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= S_IDLE;
            step        <= '0;
            ra_q        <= '0;
            rb_q        <= '0;
            pa_q        <= 1'b0;
            pb_q        <= 1'b0;
            fail        <= 1'b0;
            plane_fail  <= '0;
            timeout_err <= 1'b0;
            addr_err    <= 1'b0;
            ce_n        <= 1'b1;
        end else begin
            case (st)
                S_IDLE: begin
                    if (req_valid) begin
                        step        <= '0;
                        fail        <= 1'b0;
                        plane_fail  <= '0;
                        timeout_err <= 1'b0;
                        addr_err    <= 1'b0;
                        ra_q        <= merge_row(row_a, row_b, PAGE_BITS);
                        rb_q        <= merge_row(row_b, row_b, PAGE_BITS);
                        pa_q        <= row_a[PAGE_BITS];
                        pb_q        <= row_b[PAGE_BITS];
                        if (row_a[PAGE_BITS] == row_b[PAGE_BITS]) begin
                            addr_err <= 1'b1;
                            fail     <= 1'b1;
                            st       <= S_FIN;
                        end else begin
                            ce_n <= 1'b0;
                            st   <= S_RUN;
                        end
                    end
                end
                S_RUN: begin
                    if (op_done) begin
                        if (tmo_hit) begin
                            fail        <= 1'b1;
                            timeout_err <= 1'b1;
                            ce_n        <= 1'b1;
                            st          <= S_FIN;
                        end else begin
                            case (step)
                                STEP_RD_SR: begin
                                    if (!st_err) begin
                                        ce_n <= 1'b1;
                                        st   <= S_FIN;
                                    end else begin
                                        step <= step + 1'b1;
                                    end
                                end
                                STEP_RD_PA: begin
                                    plane_fail[pa_q] <= st_err;
                                    step             <= step + 1'b1;
                                end
                                STEP_RD_PB: begin
                                    plane_fail[pb_q] <= st_err;
                                    fail             <= 1'b1;
                                    ce_n             <= 1'b1;
                                    st               <= S_FIN;
                                end
                                default: step <= step + 1'b1;
                            endcase
                        end
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> busy);
    assert_done_returns_idle_R1: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && req_ready));
    assert_reject_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && (row_a[PAGE_BITS] == row_b[PAGE_BITS]))
        |=> (ce_n && done && addr_err));
    assert_timeout_abort_R9: assert property (@(posedge clk) disable iff (rst)
        (st == S_RUN && op_done && tmo_hit) |=> (ce_n && done && timeout_err));
    assert_plane_fail_needs_fail_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> (fail || plane_fail == 2'b00));
    assert_planes_differ_R5: assert property (@(posedge clk) disable iff (rst)
        (st == S_RUN) |-> (pa_q != pb_q));

endmodule

// File: rtl/nand_dual_erase.sv
module nand_dual_erase
    import nde_pkg::*;
#(
    parameter int PAGE_BITS = 6,
    parameter int WB_CYC    = 4,
    parameter int RD_CYC    = 2,
    parameter int TMO_W     = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [23:0]      req_row_a,
    input  logic [23:0]      req_row_b,
    input  logic [TMO_W-1:0] tmo_limit,
    output logic             busy,
    output logic             done,
    output logic             fail,
    output logic [1:0]       plane_fail,
    output logic             timeout_err,
    output logic             addr_err,
    output logic             nand_ce_n,
    output logic             nand_cle,
    output logic             nand_ale,
    output logic             nand_we_n,
    output logic             nand_re_n,
    output logic [7:0]       nand_io_out,
    output logic             nand_io_oe,
    input  logic [7:0]       nand_io_in,
    input  logic             nand_rb
);

    bus_op_t    op;
    logic       op_valid;
    logic       op_done;
    logic       tmo_hit;
    logic [7:0] rd_data;

    nde_seq #(.PAGE_BITS(PAGE_BITS)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .row_a       (req_row_a),
        .row_b       (req_row_b),
        .busy        (busy),
        .done        (done),
        .fail        (fail),
        .plane_fail  (plane_fail),
        .timeout_err (timeout_err),
        .addr_err    (addr_err),
        .ce_n        (nand_ce_n),
        .op_valid    (op_valid),
        .op          (op),
        .op_done     (op_done),
        .tmo_hit     (tmo_hit),
        .rd_data     (rd_data)
    );

    nde_bus_engine #(.WB_CYC(WB_CYC), .RD_CYC(RD_CYC), .TMO_W(TMO_W)) u_eng (
        .clk       (clk),
        .rst       (rst),
        .op_valid  (op_valid),
        .op        (op),
        .tmo_limit (tmo_limit),
        .rb_ready  (nand_rb),
        .io_in     (nand_io_in),
        .op_done   (op_done),
        .tmo_hit   (tmo_hit),
        .rd_data   (rd_data),
        .cle       (nand_cle),
        .ale       (nand_ale),
        .we_n      (nand_we_n),
        .re_n      (nand_re_n),
        .io_out    (nand_io_out),
        .io_oe     (nand_io_oe)
    );

    assert_ce_during_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        (!nand_we_n || !nand_re_n) |-> !nand_ce_n);
    assert_idle_bus_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (nand_we_n && nand_re_n));

endmodule

// File: tb/sim_nand_dual_erase.sv
module sim_nand_dual_erase;

    localparam int PB = 6;
    localparam int TW = 20;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid;
    logic          req_ready;
    logic [23:0]   req_row_a;
    logic [23:0]   req_row_b;
    logic [TW-1:0] tmo_limit;
    logic          busy, done, fail, timeout_err, addr_err;
    logic [1:0]    plane_fail;
    logic          nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
    logic [7:0]    nand_io_out;
    logic [7:0]    nand_io_in;
    logic          nand_rb;

    always #5 clk = ~clk;

    nand_dual_erase u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_row_a(req_row_a), .req_row_b(req_row_b), .tmo_limit(tmo_limit),
        .busy(busy), .done(done), .fail(fail), .plane_fail(plane_fail),
        .timeout_err(timeout_err), .addr_err(addr_err), .nand_ce_n(nand_ce_n),
        .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
        .nand_re_n(nand_re_n), .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe),
        .nand_io_in(nand_io_in), .nand_rb(nand_rb)
    );

    int n_chk = 0;
    int n_fail = 0;

    // Flash model, evaluated on the falling edge
    logic [9:0] lat_log [0:31];
    int         lat_n = 0;
    logic [9:0] exp_log [0:31];
    int         exp_n = 0;
    int         busy_cnt = 0;
    int         bl_short = 5;
    int         bl_long = 20;
    logic [7:0] sr_val = 8'h60;
    logic [1:0] enh_err = 2'b00;
    logic [7:0] last_cmd = 8'h00;
    logic [7:0] first_adr = 8'h00;
    int         adr_idx = 0;
    logic       we_q = 1'b1;
    logic       ce_low_seen = 1'b0;
    int         viol_r3 = 0;
    int         viol_r10 = 0;
    int         viol_ce = 0;

    assign nand_rb = (busy_cnt == 0);
    assign nand_io_in = nand_re_n ? 8'h00 :
                        (last_cmd == 8'h78) ? (8'h60 | {7'd0, enh_err[first_adr[PB]]}) : sr_val;

    always @(negedge clk) begin
        if (busy_cnt > 0) busy_cnt = busy_cnt - 1;
        if (!rst) begin
            if (nand_cle && nand_ale) viol_r10++;
            if (!nand_we_n && !nand_re_n) viol_r10++;
            if (!nand_we_n && !nand_io_oe) viol_r10++;
            if (!nand_re_n && nand_io_oe) viol_r10++;
            if ((!nand_we_n || !nand_re_n) && nand_ce_n) viol_ce++;
            if ((!nand_we_n || !nand_re_n) && busy_cnt > 0) viol_r3++;
            if (!nand_ce_n) ce_low_seen = 1'b1;
            if (nand_we_n && !we_q) begin
                if (lat_n < 32) lat_log[lat_n] = {nand_cle, nand_ale, nand_io_out};
                lat_n++;
                if (nand_cle) begin
                    last_cmd = nand_io_out;
                    adr_idx = 0;
                    if (nand_io_out == 8'hD1) busy_cnt = bl_short;
                    if (nand_io_out == 8'hD0) busy_cnt = bl_long;
                end else if (nand_ale) begin
                    if (adr_idx == 0) first_adr = nand_io_out;
                    adr_idx++;
                end
            end
        end
        we_q = nand_we_n;
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [23:0] fix_row(input logic [23:0] own, input logic [23:0] src);
        return {src[23:PB+1], own[PB], {PB{1'b0}}};
    endfunction

    task automatic push_w(input bit is_cmd, input logic [7:0] d);
        exp_log[exp_n] = {is_cmd, !is_cmd, d};
        exp_n++;
    endtask

    task automatic push_row(input logic [23:0] r);
        push_w(0, r[7:0]);
        push_w(0, r[15:8]);
        push_w(0, r[23:16]);
    endtask

    // tmo_stage: 0 none, 1 during queue wait, 2 during erase wait
    task automatic build_exp(input logic [23:0] ra, input logic [23:0] rb,
                             input bit serr, input int tmo_stage);
        logic [23:0] fa, fb;
        exp_n = 0;
        fa = fix_row(ra, rb);
        fb = fix_row(rb, rb);
        if (ra[PB] == rb[PB]) return;
        push_w(1, 8'h60); push_row(fa); push_w(1, 8'hD1);
        if (tmo_stage == 1) return;
        push_w(1, 8'h60); push_row(fb); push_w(1, 8'hD0);
        if (tmo_stage == 2) return;
        push_w(1, 8'h70);
        if (!serr) return;
        push_w(1, 8'h78); push_row(fa);
        push_w(1, 8'h78); push_row(fb);
    endtask

    task automatic run_case(input logic [23:0] ra, input logic [23:0] rb,
                            input bit serr, input logic [1:0] enh,
                            input int bs, input int bl, input int tlim, input int tmo_stage);
        int  cyc;
        bit  same;
        bit  e_fail;
        logic [1:0] e_pf;
        same = (ra[PB] == rb[PB]);
        @(posedge clk); #2;
        sr_val = 8'h60 | {7'd0, serr};
        enh_err = enh;
        bl_short = bs;
        bl_long = bl;
        tmo_limit = TW'(tlim);
        lat_n = 0;
        ce_low_seen = 1'b0;
        viol_r3 = 0; viol_r10 = 0; viol_ce = 0;
        check(req_ready == 1'b1, "R1", "ready when idle", req_ready, 1);
        req_valid = 1'b1;
        req_row_a = ra;
        req_row_b = rb;
        @(posedge clk); #2;
        req_valid = 1'b0;
        req_row_a = $urandom;
        req_row_b = $urandom;
        check(busy == 1'b1 && req_ready == 1'b0, "R1", "busy after accept",
              {busy, req_ready}, 2'b10);
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk); #2;
            cyc++;
            if (!done) check(busy == 1'b1, "R1", "busy held", busy, 1);
        end
        check(done == 1'b1, "R1", "done reached", done, 1);
        build_exp(ra, rb, serr, tmo_stage);
        e_fail = same || (tmo_stage != 0) || serr;
        e_pf = (!same && tmo_stage == 0 && serr) ? enh : 2'b00;
        check(fail == e_fail, same ? "R6" : (tmo_stage != 0 ? "R9" : "R7"), "fail", fail, e_fail);
        check(plane_fail == e_pf, "R8", "plane_fail", plane_fail, e_pf);
        check(addr_err == same, "R6", "addr_err", addr_err, same);
        check(timeout_err == (tmo_stage != 0), "R9", "timeout_err", timeout_err, tmo_stage != 0);
        check(lat_n == exp_n, same ? "R6" : "R2", "latched byte count", lat_n, exp_n);
        for (int i = 0; i < exp_n && i < lat_n; i++) begin
            string tg;
            tg = (i < 5) ? "R2" : (i < 10) ? "R4" : (i == 10) ? "R7" : "R8";
            check(lat_log[i] == exp_log[i], tg, $sformatf("byte %0d {cle,ale,data}", i),
                  lat_log[i], exp_log[i]);
        end
        if (!same && lat_n >= 7) begin
            check(lat_log[1][PB-1:0] == '0 && lat_log[6][PB-1:0] == '0, "R5",
                  "page bits zero", {lat_log[1][7:0], lat_log[6][7:0]}, 0);
            check(lat_log[1][PB] == ra[PB] && lat_log[6][PB] == rb[PB], "R5",
                  "plane bits", {lat_log[1][PB], lat_log[6][PB]}, {ra[PB], rb[PB]});
            check(lat_log[3][7:0] == rb[23:16] && lat_log[2][7] == rb[15], "R5",
                  "block from row B", lat_log[3][7:0], rb[23:16]);
        end
        if (same) check(ce_low_seen == 1'b0, "R6", "chip enable untouched", ce_low_seen, 0);
        check(viol_r3 == 0, "R3", "strobe while flash busy", viol_r3, 0);
        check(viol_r10 == 0, "R10", "strobe exclusivity", viol_r10, 0);
        check(viol_ce == 0, "R2", "strobe without chip enable", viol_ce, 0);
        @(posedge clk); #2;
        check(done == 1'b0 && busy == 1'b0 && nand_ce_n == 1'b1, "R1", "single done pulse",
              {done, busy, nand_ce_n}, 3'b001);
        if (tmo_stage != 0)
            check(lat_n == exp_n, "R9", "no writes after abort", lat_n, exp_n);
        cyc = 0;
        while (!nand_rb && cyc < 5000) begin
            @(posedge clk); #2;
            cyc++;
        end
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rst = 1'b1;
        req_valid = 1'b0;
        req_row_a = '0;
        req_row_b = '0;
        tmo_limit = TW'(3000);
        repeat (3) @(posedge clk);
        #2;
        rst = 1'b0;
        @(posedge clk); #2;
        check(req_ready && !busy && !done && nand_ce_n && nand_we_n && nand_re_n
              && !nand_cle && !nand_ale, "R1", "reset state",
              {req_ready, busy, done, nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale},
              8'b10011100);

        // directed
        run_case(24'h12_34_00, 24'hAB_CD_40, 1'b1, 2'b01, 6, 30, 3000, 0);
        run_case(24'h55_AA_7F, 24'h01_02_3F, 1'b1, 2'b10, 6, 30, 3000, 0);
        run_case(24'h0F_0F_40, 24'hF0_F0_00, 1'b1, 2'b11, 6, 30, 3000, 0);
        run_case(24'h12_34_00, 24'hAB_CD_40, 1'b0, 2'b11, 6, 30, 3000, 0);
        run_case(24'h11_11_40, 24'h22_22_40, 1'b0, 2'b00, 6, 30, 3000, 0);
        run_case(24'h33_33_00, 24'h44_44_00, 1'b1, 2'b11, 6, 30, 3000, 0);
        run_case(24'h12_34_00, 24'hAB_CD_40, 1'b0, 2'b00, 200, 30, 50, 1);
        run_case(24'h12_34_40, 24'hAB_CD_00, 1'b0, 2'b00, 6, 400, 100, 2);
        run_case(24'hFF_FF_BF, 24'h00_00_40, 1'b0, 2'b00, 1, 1, 3000, 0);

        // seeded random
        for (int k = 0; k < 30; k++) begin
            logic [23:0] ra, rb;
            bit serr;
            logic [1:0] enh;
            ra = 24'($urandom);
            rb = 24'($urandom);
            if (($urandom % 6) != 0) rb[PB] = ~ra[PB];
            serr = 1'($urandom);
            enh = 2'($urandom);
            run_case(ra, rb, serr, enh, 1 + int'($urandom % 20), 5 + int'($urandom % 80), 3000, 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule